// File: doc/BRIEF.md
# Double-precision to unsigned integer converter

This block takes an IEEE-754 binary64 operand and turns it into an unsigned integer. The integer is either 64 bits wide or 32 bits wide. The operand is rounded first. The rounding uses either a caller-supplied rounding mode or, when the truncate select is set, rounding toward zero. Values that cannot be represented saturate: negative values clamp to zero, and values that are too large clamp to all ones.

Two flag pulses accompany each result:
- a NaN-invalid flag, raised for any NaN input;
- a conversion-invalid flag, raised for any other operand that had to be clamped.

The pulses are meant to be ORed into an exception status register elsewhere.

The block has one register stage. An operand presented with `valid_i` gives its result, and its flags, on the following clock cycle. In word mode the 32-bit result sits in the low half of the 64-bit output.

Top module: `fp_to_uint_cvt`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by one clock. Result and flags for an operand appear in that same cycle. Both flags are low whenever `valid_o` is low.
- R2: A NaN operand (exponent field bits 62:52 all ones, fraction bits 51:0 non-zero, either sign) gives result 0, raises `nan_inv_o` and leaves `cvt_inv_o` low.
- R3: A positive operand whose rounded value exceeds the width's maximum (2^64-1 doubleword, 2^32-1 word), including +infinity, gives all ones for that width and raises `cvt_inv_o`.
- R4: A negative operand whose rounded magnitude is non-zero, including -infinity, gives 0 and raises `cvt_inv_o`.
- R5: A negative operand that rounds to zero (such as -0.3 truncated, -0.5 to nearest, or -0.0) gives 0 with no flag.
- R6: With `trunc_i`=1 the operand is rounded toward zero, whatever `rmode_i` holds.
- R7: With `trunc_i`=0, `rmode_i` selects the rounding: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R8: With `word_i`=1 the range is 32 bits, the result occupies bits 31:0 and bits 63:32 are zero. With `word_i`=0 the range is 64 bits.
- R9: Subnormal operands give 0, or 1 where the mode rounds a positive one up. A negative subnormal rounded toward -infinity is handled as in R4.
- R10: In-range operands with an integer value convert exactly, up to 2^64-2048 in doubleword mode.
- R11: While `rst_ni` is low, `valid_o`, `result_o`, `nan_inv_o` and `cvt_inv_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| op_i | input | 64 | binary64 operand |
| word_i | input | 1 | 1: 32-bit result, 0: 64-bit result |
| trunc_i | input | 1 | 1: round toward zero, ignoring rmode_i |
| rmode_i | input | 2 | Rounding mode (R7 encoding) |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| result_o | output | 64 | Converted unsigned integer |
| nan_inv_o | output | 1 | NaN-invalid pulse |
| cvt_inv_o | output | 1 | Conversion-invalid pulse |

## Verification
The assertions assume three things about the inputs:
- `op_i`, `word_i`, `trunc_i` and `rmode_i` carry known values in every cycle where `valid_i` is high;
- `valid_i` is low while reset is held;
- the output checks that look one cycle back therefore compare against a real, registered operand.

The stimulus meets these assumptions. It drives every input on the falling edge from a reset state where everything is zero. It holds `valid_i` low until reset has been released. Idle cycles are mixed in between operands. Random operands have their exponent limited to the band around the 32-bit and 64-bit range edges, so that the rounding and saturation boundaries are hit often.

// File: rtl/fcvt_pkg.sv
`timescale 1ns/1ps
package fcvt_pkg;
  localparam int FP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic [EXP_W-1:0] exp_eff;
    logic [SIG_W-1:0] sig;
  } fp_unpk_t;
endpackage

// File: rtl/fcvt_unpack.sv
`timescale 1ns/1ps
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [FP_W-1:0] op_i,
  output fp_unpk_t        unpk_o
);
  logic [EXP_W-1:0]  exp_raw;
  logic [FRAC_W-1:0] frac;
  logic              exp_nz;

  assign exp_raw = op_i[FP_W-2 -: EXP_W];
  assign frac    = op_i[FRAC_W-1:0];
  assign exp_nz  = |exp_raw;

  always_comb begin
    unpk_o.sign    = op_i[FP_W-1];
    unpk_o.is_nan  = (&exp_raw) & (|frac);
    // subnormals share the scale of the smallest normal exponent
    unpk_o.exp_eff = exp_nz ? exp_raw : EXP_W'(1);
    unpk_o.sig     = {exp_nz, frac};
  end
endmodule

// File: rtl/fcvt_align.sv
`timescale 1ns/1ps
module fcvt_align
  import fcvt_pkg::*;
#(
  parameter int WIDE_W = 64
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [SIG_W-1:0]  sig_i,
  output logic [WIDE_W-1:0] int_o,
  output logic              guard_o,
  output logic              sticky_o,
  output logic              big_o
);
  localparam int FIX_W = 2 * WIDE_W;
  localparam int SH_W  = $clog2(FIX_W);
  // exponent placing the significand LSB at fixed-point bit 0
  localparam int LO_E  = BIAS + FRAC_W - WIDE_W;
  // smallest exponent whose magnitude needs more than WIDE_W bits
  localparam int HI_E  = BIAS + WIDE_W;

  logic             tiny;
  logic [SH_W-1:0]  sh;
  logic [FIX_W-1:0] fix;

  assign big_o = exp_i >= EXP_W'(HI_E);
  assign tiny  = exp_i <  EXP_W'(LO_E);
  assign sh    = SH_W'(exp_i - EXP_W'(LO_E));
  assign fix   = {{(FIX_W-SIG_W){1'b0}}, sig_i} << sh;

  always_comb begin
    if (tiny) begin
      int_o    = '0;
      guard_o  = 1'b0;
      sticky_o = |sig_i;
    end else if (big_o) begin
      int_o    = '0;
      guard_o  = 1'b0;
      sticky_o = 1'b0;
    end else begin
      int_o    = fix[FIX_W-1:WIDE_W];
      guard_o  = fix[WIDE_W-1];
      sticky_o = |fix[WIDE_W-2:0];
    end
  end
endmodule

// File: rtl/fcvt_round.sv
`timescale 1ns/1ps
module fcvt_round
  import fcvt_pkg::*;
#(
  parameter int WIDE_W = 64
) (
  input  logic [WIDE_W-1:0] int_i,
  input  logic              guard_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  rmode_e            mode_i,
  output logic [WIDE_W:0]   mag_o
);
  logic inexact;
  logic up;

  assign inexact = guard_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      RM_NEAR: up = guard_i & (sticky_i | int_i[0]);
      RM_ZERO: up = 1'b0;
      RM_POS:  up = inexact & ~sign_i;
      RM_NEG:  up = inexact & sign_i;
      default: up = 1'b0;
    endcase
  end

  assign mag_o = {1'b0, int_i} + {{WIDE_W{1'b0}}, up};
endmodule

// File: rtl/fcvt_sat.sv
`timescale 1ns/1ps
module fcvt_sat #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              is_nan_i,
  input  logic              sign_i,
  input  logic              big_i,
  input  logic              word_i,
  input  logic [WIDE_W:0]   mag_i,
  output logic [WIDE_W-1:0] res_o,
  output logic              nan_o,
  output logic              cvt_o
);
  localparam logic [WIDE_W-1:0] NARROW_ONES = WIDE_W'({NARROW_W{1'b1}});

  logic wide_over;
  logic narrow_over;
  logic over;

  assign wide_over = mag_i[WIDE_W];

  generate
    if (NARROW_W < WIDE_W) begin : g_split
      assign narrow_over = |mag_i[WIDE_W:NARROW_W];
    end else begin : g_same
      assign narrow_over = mag_i[WIDE_W];
    end
  endgenerate

  assign over = big_i | (word_i ? narrow_over : wide_over);

  always_comb begin
    res_o = '0;
    nan_o = 1'b0;
    cvt_o = 1'b0;
    if (is_nan_i) begin
      nan_o = 1'b1;
    end else if (sign_i) begin
      cvt_o = big_i | (|mag_i);
    end else if (over) begin
      cvt_o = 1'b1;
      res_o = word_i ? NARROW_ONES : '1;
    end else begin
      res_o = word_i ? WIDE_W'(mag_i[NARROW_W-1:0]) : mag_i[WIDE_W-1:0];
    end
  end
endmodule

// File: rtl/fp_to_uint_cvt.sv
`timescale 1ns/1ps
module fp_to_uint_cvt
  import fcvt_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FP_W-1:0]   op_i,
  input  logic              word_i,
  input  logic              trunc_i,
  input  logic [1:0]        rmode_i,
  output logic              valid_o,
  output logic [WIDE_W-1:0] result_o,
  output logic              nan_inv_o,
  output logic              cvt_inv_o
);
  fp_unpk_t          unpk;
  rmode_e            mode;
  logic [WIDE_W-1:0] int_part;
  logic              guard, sticky, big;
  logic [WIDE_W:0]   mag;
  logic [WIDE_W-1:0] res_d;
  logic              nan_d, cvt_d;

  assign mode = trunc_i ? RM_ZERO : rmode_e'(rmode_i);

  fcvt_unpack u_unpack (
    .op_i   (op_i),
    .unpk_o (unpk)
  );

  fcvt_align #(.WIDE_W(WIDE_W)) u_align (
    .exp_i    (unpk.exp_eff),
    .sig_i    (unpk.sig),
    .int_o    (int_part),
    .guard_o  (guard),
    .sticky_o (sticky),
    .big_o    (big)
  );

  fcvt_round #(.WIDE_W(WIDE_W)) u_round (
    .int_i    (int_part),
    .guard_i  (guard),
    .sticky_i (sticky),
    .sign_i   (unpk.sign),
    .mode_i   (mode),
    .mag_o    (mag)
  );

  fcvt_sat #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_sat (
    .is_nan_i (unpk.is_nan),
    .sign_i   (unpk.sign),
    .big_i    (big),
    .word_i   (word_i),
    .mag_i    (mag),
    .res_o    (res_d),
    .nan_o    (nan_d),
    .cvt_o    (cvt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      nan_inv_o <= 1'b0;
      cvt_inv_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      nan_inv_o <= valid_i & nan_d;
      cvt_inv_o <= valid_i & cvt_d;
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/fp_to_uint_cvt_chk.sv
`timescale 1ns/1ps
module fp_to_uint_cvt_chk #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [63:0]       op_i,
  input logic              word_i,
  input logic              valid_o,
  input logic [WIDE_W-1:0] result_o,
  input logic              nan_inv_o,
  input logic              cvt_inv_o
);
  logic op_nan;
  logic op_pinf;
  assign op_nan  = (&op_i[62:52]) & (|op_i[51:0]);
  assign op_pinf = ~op_i[63] & (&op_i[62:52]) & ~(|op_i[51:0]);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(nan_inv_o || cvt_inv_o)); // R1
  AST_NAN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_nan) |=> (nan_inv_o && !cvt_inv_o && result_o == '0)); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nan_inv_o && cvt_inv_o)); // R2
  AST_PINF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_pinf) |=> (cvt_inv_o && result_o != '0)); // R3
  AST_CVT_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cvt_inv_o |-> (result_o == '0 || result_o == '1 ||
                   result_o == WIDE_W'({NARROW_W{1'b1}}))); // R3
  AST_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[63]) |=> result_o == '0); // R4
  AST_WORD_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i) |=> result_o[WIDE_W-1:NARROW_W] == '0); // R8
endmodule

bind fp_to_uint_cvt fp_to_uint_cvt_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .word_i    (word_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .nan_inv_o (nan_inv_o),
  .cvt_inv_o (cvt_inv_o)
);

// File: tb/fp_to_uint_cvt_tb.sv
`timescale 1ns/1ps
module fp_to_uint_cvt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] op_i = '0;
  logic        word_i = 1'b0;
  logic        trunc_i = 1'b0;
  logic [1:0]  rmode_i = 2'b00;
  logic        valid_o;
  logic [63:0] result_o;
  logic        nan_inv_o, cvt_inv_o;

  always #5 clk = ~clk;

  fp_to_uint_cvt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .word_i(word_i), .trunc_i(trunc_i), .rmode_i(rmode_i),
    .valid_o(valid_o), .result_o(result_o),
    .nan_inv_o(nan_inv_o), .cvt_inv_o(cvt_inv_o)
  );

  typedef struct {
    bit          v;
    logic [63:0] r;
    bit          fn;
    bit          fc;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // behavioural reference: quotient/remainder against half
  function automatic exp_t model(logic [63:0] op, bit wd, bit tr, logic [1:0] rm);
    exp_t x;
    int e, ue, n, cmp;
    logic [63:0] sig, qv, rem, half;
    logic [64:0] mag, lim;
    logic [1:0] m;
    bit big, up, inx;
    x.v = 1; x.r = '0; x.fn = 0; x.fc = 0; x.tag = "";
    e = int'(op[62:52]);
    if (e == 2047 && op[51:0] != 0) begin x.fn = 1; return x; end
    if (e == 2047) begin
      x.fc = 1;
      x.r  = op[63] ? 64'd0 : (wd ? 64'hFFFF_FFFF : '1);
      return x;
    end
    ue  = (e == 0) ? -1022 : e - 1023;
    sig = {11'b0, (e != 0), op[51:0]};
    big = 0; qv = '0; rem = '0; half = '0; cmp = -1;
    if (ue >= 64) big = 1;
    else if (ue >= 52) qv = sig << (ue - 52);
    else begin
      n = 52 - ue;
      if (n > 60) begin
        qv = '0; rem = sig;
      end else begin
        qv   = sig >> n;
        rem  = sig & ((64'd1 << n) - 64'd1);
        half = 64'd1 << (n - 1);
        cmp  = (rem < half) ? -1 : ((rem == half) ? 0 : 1);
      end
    end
    inx = (rem != 0);
    m = tr ? 2'b01 : rm;
    case (m)
      2'b00:   up = inx && (cmp > 0 || (cmp == 0 && qv[0]));
      2'b01:   up = 0;
      2'b10:   up = inx && !op[63];
      default: up = inx && op[63];
    endcase
    mag = {1'b0, qv} + 65'(up);
    lim = wd ? 65'h0_FFFF_FFFF : 65'h0_FFFF_FFFF_FFFF_FFFF;
    if (op[63]) begin
      if (big || mag != 0) x.fc = 1;
    end else if (big || mag > lim) begin
      x.fc = 1; x.r = lim[63:0];
    end else x.r = mag[63:0];
    return x;
  endfunction

  task automatic drive(logic [63:0] op, bit wd, bit tr, logic [1:0] rm, string tag);
    exp_t x;
    @(negedge clk);
    valid_i = 1; op_i = op; word_i = wd; trunc_i = tr; rmode_i = rm;
    x = model(op, wd, tr, rm);
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle();
    exp_t x;
    @(negedge clk);
    valid_i = 0; op_i = '0;
    x.v = 0; x.r = '0; x.fn = 0; x.fc = 0; x.tag = "R1";
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && q.size() > 0) begin
      cur = q.pop_front();
      chk(cur.tag, "valid_o", 64'(valid_o), 64'(cur.v));
      if (cur.v) begin
        chk(cur.tag, "result_o", result_o, cur.r);
        chk(cur.tag, "nan_inv_o", 64'(nan_inv_o), 64'(cur.fn));
        chk(cur.tag, "cvt_inv_o", 64'(cvt_inv_o), 64'(cur.fc));
      end else begin
        chk(cur.tag, "flags idle", 64'({nan_inv_o, cvt_inv_o}), 64'd0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "valid_o", 64'(valid_o), 64'd0);
    chk("R11", "result_o", result_o, 64'd0);
    chk("R11", "flags", 64'({nan_inv_o, cvt_inv_o}), 64'd0);
    rst_n = 1;

    drive(64'h3FF0000000000000, 0, 0, 2'b00, "R10");   // 1.0
    drive(64'h43E0000000000000, 0, 0, 2'b00, "R10");   // 2^63
    drive(64'h43EFFFFFFFFFFFFF, 0, 0, 2'b00, "R10");   // 2^64-2048
    drive(64'h4004000000000000, 0, 0, 2'b00, "R7");    // 2.5 -> 2
    drive(64'h400C000000000000, 0, 0, 2'b00, "R7");    // 3.5 -> 4
    drive(64'h400599999999999A, 0, 0, 2'b10, "R7");    // 2.7 up
    drive(64'h400599999999999A, 0, 0, 2'b11, "R7");    // 2.7 down
    drive(64'h400599999999999A, 0, 0, 2'b01, "R7");
    drive(64'h3FE0000000000000, 0, 0, 2'b00, "R7");    // 0.5 -> 0
    drive(64'hBFE0000000000000, 0, 0, 2'b11, "R7");    // -0.5 -> -1
    idle();
    drive(64'h400599999999999A, 0, 1, 2'b00, "R6");
    drive(64'h400C000000000000, 0, 1, 2'b10, "R6");
    drive(64'h7FF8000000000000, 0, 0, 2'b00, "R2");
    drive(64'h7FF0000000000001, 1, 0, 2'b00, "R2");
    drive(64'hFFF8000000000000, 0, 1, 2'b00, "R2");
    drive(64'h7FF0000000000000, 0, 0, 2'b00, "R3");
    drive(64'h7FF0000000000000, 1, 0, 2'b00, "R3");
    drive(64'h43F0000000000000, 0, 0, 2'b00, "R3");    // 2^64
    drive(64'h41F0000000000000, 1, 0, 2'b00, "R3");    // 2^32 word
    drive(64'h41EFFFFFFFF00000, 1, 0, 2'b00, "R3");    // 2^32-0.5 rounds up
    drive(64'h41EFFFFFFFE00000, 1, 0, 2'b00, "R8");    // 2^32-1
    drive(64'h41EFFFFFFFF00000, 1, 1, 2'b00, "R8");
    drive(64'h41F0000000000000, 0, 0, 2'b00, "R8");
    drive(64'hBFF0000000000000, 0, 0, 2'b00, "R4");
    drive(64'hFFF0000000000000, 1, 0, 2'b00, "R4");
    drive(64'hC3F0000000000000, 0, 0, 2'b00, "R4");
    drive(64'hBFD3333333333333, 0, 1, 2'b00, "R5");    // -0.3
    drive(64'h8000000000000000, 0, 0, 2'b11, "R5");    // -0.0
    drive(64'hBFE0000000000000, 1, 0, 2'b00, "R5");
    drive(64'h0000000000000001, 0, 0, 2'b00, "R9");
    drive(64'h0000000000000001, 0, 0, 2'b10, "R9");
    drive(64'h000FFFFFFFFFFFFF, 1, 0, 2'b10, "R9");
    drive(64'h8000000000000001, 0, 0, 2'b11, "R9");
    idle();
    idle();

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      r[62:52] = 11'(990 + $urandom_range(0, 110));
      if (i % 97 == 0) r[62:52] = 11'h7FF;
      if (i % 89 == 0) r[62:52] = 11'h000;
      drive(r, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
            2'($urandom_range(0, 3)), "R7");
      if (i % 7 == 0) idle();
    end

    @(negedge clk);
    valid_i = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule